// File: doc/BRIEF.md
# Saturating Fixed-Point Vector ALU Lane

This block is one arithmetic slice of a fixed-point vector pipeline. Each cycle it can take one operation: an opcode and two 32-bit operands. It returns a 32-bit result three register stages later, in issue order, together with an error bit and a saturation bit. Addition, subtraction and every accumulator update clamp to the signed 32-bit range instead of wrapping. This suits networks that hold 16-bit weights and activations and keep 32-bit intermediate sums. A sticky status pin records that any result has clamped since reset.

The lane has a single private accumulator. The multiply-accumulate and accumulate opcodes update it, and the updated value is returned as their result. A parameter chooses between two lane types that are otherwise the same. One type has a 16x16 signed multiplier. The other has no multiplier and flags every multiply-family opcode as illegal.

Both the input and the output are valid/ready streams. An operation transfers on an edge where `in_valid` and `in_ready` are both high. A result transfers on an edge where `out_valid` and `out_ready` are both high. While a result waits in the output register with `out_ready` low, the whole pipeline freezes and `in_ready` is low. Bubbles already inside the pipeline are not squeezed out.

Top module: `sat_vec_lane`

## Requirements
- R1: `in_ready` is low exactly while `out_valid` is high and `out_ready` is low. During such a stall the output result, error and saturation bits hold steady, and no operation in flight is lost or reordered.
- R2: An operation accepted at a clock edge appears on `out_valid`/`out_data` after the third rising edge, counting the accepting edge as the first. A new operation can be accepted every cycle, and results leave in issue order.
- R3: Opcode 0 (add) and opcode 1 (subtract, A minus B) are signed. A result above 0x7FFFFFFF is replaced by 0x7FFFFFFF, and a result below 0x80000000 is replaced by 0x80000000. `out_sat` is high exactly for a clamped result.
- R4: Opcodes 2, 3 and 4 are bitwise AND, OR and XOR over all 32 bits.
- R5: Opcodes 5, 6 and 7 shift A left logically, right logically, and right arithmetically. The shift count is bits 4:0 of B, and the higher bits of B are ignored.
- R6: Opcode 8 multiplies bits 15:0 of A by bits 15:0 of B as signed values and returns the exact 32-bit product. Bits 31:16 of both operands are ignored.
- R7: Opcode 9 loads the accumulator with the product. Opcode 10 adds the product to the accumulator. Opcode 11 adds all of A to the accumulator. The two additions saturate as in R3 and set `out_sat` when they clamp. Each of these opcodes returns the new accumulator value, and a sequence issued back to back gives the same values as the same sequence issued one at a time.
- R8: `sat_status` goes high with the first result whose `out_sat` is high and stays high until reset.
- R9: In the lane without a multiplier, opcodes 8, 9 and 10 return `out_err`=1 and `out_data`=0, and they leave the accumulator unchanged.
- R10: Opcodes 12 to 15 are reserved in both lane types. They return `out_err`=1, `out_data`=0 and `out_sat`=0, and they leave the accumulator unchanged.
- R11: After reset, `out_valid` and `sat_status` are low, `in_ready` is high and the accumulator holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Lane can take an operation this cycle |
| in_op | input | 4 | Opcode (encodings in R3 to R10) |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Result |
| out_err | output | 1 | Operation was illegal for this lane |
| out_sat | output | 1 | Result was clamped |
| sat_status | output | 1 | Sticky: some result clamped since reset |

## Verification
Two things can happen in the same cycle: a multiply-accumulate in the last stage writes the accumulator while the next accumulating operation reads it. The bench provokes this with four accumulator opcodes issued on consecutive cycles. Each retired value is compared with a running sum computed serially in the bench. Stalls on the output are a second concern. The bench holds `out_ready` low while a second operation is already in flight, then checks that the first result stays put, that `in_ready` drops, and that the second result arrives intact once the stall is released.

// File: rtl/sat_lane_pkg.sv
package sat_lane_pkg;

  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SRA  = 4'd7,
    OP_MUL  = 4'd8,
    OP_MACZ = 4'd9,
    OP_MAC  = 4'd10,
    OP_ACC  = 4'd11
  } lane_op_e;

  typedef struct packed {
    lane_op_e op;
    logic     illegal;
    logic     mul_fam;
    logic     acc_op;
    logic     acc_load;
  } lane_ctrl_t;

endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import sat_lane_pkg::*;
#(
  parameter bit HAS_MUL = 1'b1
) (
  input  logic [OPW-1:0] op_raw,
  output lane_ctrl_t     ctrl
);

  logic reserved;
  logic mul_fam;

  always_comb begin
    reserved = (op_raw > OP_ACC);
    mul_fam  = (op_raw == OP_MUL) || (op_raw == OP_MACZ) || (op_raw == OP_MAC);
    ctrl.op       = lane_op_e'(op_raw);
    ctrl.mul_fam  = mul_fam;
    ctrl.illegal  = reserved || (mul_fam && !HAS_MUL);
    ctrl.acc_op   = !ctrl.illegal &&
                    ((op_raw == OP_MACZ) || (op_raw == OP_MAC) || (op_raw == OP_ACC));
    ctrl.acc_load = !ctrl.illegal && (op_raw == OP_MACZ);
  end

endmodule

// File: rtl/lane_satadd.sv
module lane_satadd #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         clamp
);

  localparam logic [W-1:0] POS_RAIL = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_RAIL = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] y_eff;
  logic [W:0]   wide;

  always_comb begin
    y_eff = sub ? ~y : y;
    wide  = {x[W-1], x} + {y_eff[W-1], y_eff} + {{W{1'b0}}, sub};
    clamp = (wide[W] != wide[W-1]);
    if (clamp) res = wide[W] ? NEG_RAIL : POS_RAIL;
    else       res = wide[W-1:0];
  end

endmodule

// File: rtl/lane_mul.sv
module lane_mul #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] p
);

  localparam int HW = DW / 2;

  logic signed [DW-1:0] ax;
  logic signed [DW-1:0] bx;

  always_comb begin
    ax = {{(DW-HW){a[HW-1]}}, a[HW-1:0]};
    bx = {{(DW-HW){b[HW-1]}}, b[HW-1:0]};
    p  = ax * bx;
  end

endmodule

// File: rtl/sat_vec_lane.sv
module sat_vec_lane
  import sat_lane_pkg::*;
#(
  parameter int DW      = 32,
  parameter bit HAS_MUL = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic [DW-1:0]  in_a,
  input  logic [DW-1:0]  in_b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic           out_err,
  output logic           out_sat,
  output logic           sat_status
);

  localparam int SHW = $clog2(DW);
  localparam logic [DW-1:0] POS_RAIL = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_RAIL = {1'b1, {(DW-1){1'b0}}};

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // ---------------- stage 1: capture and decode ----------------
  lane_ctrl_t ctrl_in;
  lane_decode #(.HAS_MUL(HAS_MUL)) u_dec (.op_raw(in_op), .ctrl(ctrl_in));

  logic          v1;
  lane_ctrl_t    c1;
  logic [DW-1:0] a1, b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      c1 <= '0;
      a1 <= '0;
      b1 <= '0;
    end else if (adv) begin
      v1 <= in_valid;
      c1 <= ctrl_in;
      a1 <= in_a;
      b1 <= in_b;
    end
  end

  // ---------------- stage 2: compute ----------------
  logic [DW-1:0] prod;
  generate
    if (HAS_MUL) begin : g_mul
      lane_mul #(.DW(DW)) u_mul (.a(a1), .b(b1), .p(prod));
    end else begin : g_nomul
      assign prod = '0;
    end
  endgenerate

  logic [DW-1:0] as_res;
  logic          as_clamp;
  lane_satadd #(.W(DW)) u_addsub (
    .x(a1), .y(b1), .sub(c1.op == OP_SUB), .res(as_res), .clamp(as_clamp)
  );

  logic [SHW-1:0] shamt;
  logic [DW-1:0]  res_c;
  logic           sat_c;
  logic [DW-1:0]  addend_c;

  always_comb begin
    shamt    = b1[SHW-1:0];
    res_c    = '0;
    sat_c    = 1'b0;
    addend_c = prod;
    if (!c1.illegal) begin
      unique case (c1.op)
        OP_ADD, OP_SUB: begin
          res_c = as_res;
          sat_c = as_clamp;
        end
        OP_AND:  res_c = a1 & b1;
        OP_OR:   res_c = a1 | b1;
        OP_XOR:  res_c = a1 ^ b1;
        OP_SLL:  res_c = a1 << shamt;
        OP_SRL:  res_c = a1 >> shamt;
        OP_SRA:  res_c = $signed(a1) >>> shamt;
        OP_MUL, OP_MACZ, OP_MAC: res_c = prod;
        OP_ACC:  addend_c = a1;
        default: res_c = '0;
      endcase
    end
  end

  logic          v2;
  lane_ctrl_t    c2;
  logic [DW-1:0] res2, addend2;
  logic          sat2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2      <= 1'b0;
      c2      <= '0;
      res2    <= '0;
      addend2 <= '0;
      sat2    <= 1'b0;
    end else if (adv) begin
      v2      <= v1;
      c2      <= c1;
      res2    <= res_c;
      addend2 <= addend_c;
      sat2    <= sat_c;
    end
  end

  // ---------------- stage 3: accumulate and retire ----------------
  logic [DW-1:0] acc_q;
  logic [DW-1:0] acc_sum;
  logic          acc_clamp;
  logic [DW-1:0] acc_next;
  logic          acc_sat;

  lane_satadd #(.W(DW)) u_acc (
    .x(acc_q), .y(addend2), .sub(1'b0), .res(acc_sum), .clamp(acc_clamp)
  );

  always_comb begin
    acc_next = c2.acc_load ? addend2 : acc_sum;
    acc_sat  = !c2.acc_load && acc_clamp;
  end

  logic out_mul_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_err    <= 1'b0;
      out_sat    <= 1'b0;
      out_mul_q  <= 1'b0;
      sat_status <= 1'b0;
    end else if (adv) begin
      out_valid <= v2;
      out_err   <= v2 && c2.illegal;
      out_mul_q <= c2.mul_fam;
      if (v2 && c2.acc_op) begin
        acc_q    <= acc_next;
        out_data <= acc_next;
        out_sat  <= acc_sat;
        if (acc_sat) sat_status <= 1'b1;
      end else begin
        out_data <= res2;
        out_sat  <= v2 && sat2;
        if (v2 && sat2) sat_status <= 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_err) && $stable(out_sat)); // R1

  AST_NO_TAKE_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(v1) && $stable(v2)); // R1

  AST_SAT_ON_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sat |-> (out_data == POS_RAIL) || (out_data == NEG_RAIL)); // R3

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sat |-> sat_status); // R8

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    sat_status |=> sat_status); // R8

  AST_NOMUL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mul_q && (HAS_MUL == 1'b0) |-> out_err); // R9

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> (out_data == '0) && !out_sat); // R10

  AST_BAD_ACC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && v2 && c2.illegal |=> $stable(acc_q)); // R10

endmodule

// File: tb/sat_vec_lane_test.sv
`timescale 1ns/1ps
module sat_vec_lane_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // lane with multiplier
  logic        m_in_valid = 1'b0, m_out_ready = 1'b1;
  logic [3:0]  m_op = '0;
  logic [31:0] m_a = '0, m_b = '0;
  logic        m_in_ready, m_out_valid, m_err, m_sat, m_sticky;
  logic [31:0] m_data;

  // lane without multiplier
  logic        n_in_valid = 1'b0;
  logic [3:0]  n_op = '0;
  logic [31:0] n_a = '0, n_b = '0;
  logic        n_in_ready, n_out_valid, n_err, n_sat, n_sticky;
  logic [31:0] n_data;

  sat_vec_lane #(.DW(32), .HAS_MUL(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(m_in_valid), .in_ready(m_in_ready),
    .in_op(m_op), .in_a(m_a), .in_b(m_b), .out_valid(m_out_valid),
    .out_ready(m_out_ready), .out_data(m_data), .out_err(m_err),
    .out_sat(m_sat), .sat_status(m_sticky)
  );

  sat_vec_lane #(.DW(32), .HAS_MUL(1'b0)) uut_nm (
    .clk(clk), .rst_n(rst_n), .in_valid(n_in_valid), .in_ready(n_in_ready),
    .in_op(n_op), .in_a(n_a), .in_b(n_b), .out_valid(n_out_valid),
    .out_ready(1'b1), .out_data(n_data), .out_err(n_err),
    .out_sat(n_sat), .sat_status(n_sticky)
  );

  // {op, a, b, expected data, expected err, expected sat}
  localparam int NV = 24;
  localparam logic [101:0] VEC [NV] = '{
    {4'd0,  32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 1'b0, 1'b0}, // R3 add
    {4'd0,  32'h7FFF_FFF0, 32'h0000_0020, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R3 pos clamp
    {4'd0,  32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 1'b1}, // R3 neg clamp
    {4'd1,  32'h0000_0003, 32'h0000_000A, 32'hFFFF_FFF9, 1'b0, 1'b0}, // R3 sub
    {4'd1,  32'h8000_0000, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1}, // R3 sub neg clamp
    {4'd1,  32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R3 sub pos clamp
    {4'd2,  32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000, 1'b0, 1'b0}, // R4 and
    {4'd3,  32'hF0F0_F0F0, 32'h0F00_0000, 32'hFFF0_F0F0, 1'b0, 1'b0}, // R4 or
    {4'd4,  32'hFFFF_0000, 32'h0FF0_0FF0, 32'hF00F_0FF0, 1'b0, 1'b0}, // R4 xor
    {4'd5,  32'h0000_0001, 32'h0000_003F, 32'h8000_0000, 1'b0, 1'b0}, // R5 sll, count 31
    {4'd6,  32'h8000_0000, 32'h0000_0004, 32'h0800_0000, 1'b0, 1'b0}, // R5 srl
    {4'd7,  32'h8000_0000, 32'h0000_0004, 32'hF800_0000, 1'b0, 1'b0}, // R5 sra
    {4'd7,  32'h7FFF_FFFF, 32'h0000_0021, 32'h3FFF_FFFF, 1'b0, 1'b0}, // R5 sra, count 1
    {4'd8,  32'hABCD_0003, 32'h1234_FFFE, 32'hFFFF_FFFA, 1'b0, 1'b0}, // R6 3 * -2
    {4'd8,  32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 1'b0, 1'b0}, // R6 min * min
    {4'd9,  32'h0000_7FFF, 32'h0000_7FFF, 32'h3FFF_0001, 1'b0, 1'b0}, // R7 load
    {4'd10, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFE_0002, 1'b0, 1'b0}, // R7 mac
    {4'd10, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R7 mac clamp
    {4'd11, 32'h8000_0001, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0}, // R7 acc
    {4'd11, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 1'b0, 1'b0}, // R7 acc to min
    {4'd11, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0000, 1'b0, 1'b1}, // R7 acc clamp
    {4'd12, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b1, 1'b0}, // R10 reserved
    {4'd15, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0}, // R10 reserved
    {4'd11, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000, 1'b0, 1'b0}  // R10 acc untouched
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    m_in_valid = 1'b1; m_op = op; m_a = a; m_b = b;
    @(negedge clk);
    m_in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic n_issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    n_in_valid = 1'b1; n_op = op; n_a = a; n_b = b;
    @(negedge clk);
    n_in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [3:0]  PL_OP [4] = '{4'd9, 4'd10, 4'd10, 4'd11};
  localparam logic [31:0] PL_A  [4] = '{32'd100, 32'd3, 32'h0000_FFFB, 32'd8};
  localparam logic [31:0] PL_B  [4] = '{32'd2, 32'd4, 32'd10, 32'd0};
  localparam logic [31:0] PL_E  [4] = '{32'd200, 32'd212, 32'd162, 32'd170};

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=%0d expected<=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!m_out_valid && m_in_ready && !m_sticky, "R11 reset state",
        {29'd0, m_out_valid, m_in_ready, m_sticky}, 32'h2);
    chk(!n_out_valid && n_in_ready && !n_sticky, "R11 reset state nomul",
        {29'd0, n_out_valid, n_in_ready, n_sticky}, 32'h2);

    // vector table
    for (int i = 0; i < NV; i++) begin
      m_issue(VEC[i][101:98], VEC[i][97:66], VEC[i][65:34]);
      chk(m_out_valid && m_data == VEC[i][33:2] && m_err == VEC[i][1] && m_sat == VEC[i][0],
          $sformatf("R2/R3-R7/R10 vector %0d", i), m_data, VEC[i][33:2]);
    end
    chk(m_sticky, "R8 sticky after clamps", {31'd0, m_sticky}, 32'd1);

    // back-to-back accumulator traffic: R2 R7
    for (int c = 0; c < 7; c++) begin
      @(negedge clk);
      if (c >= 3)
        chk(m_out_valid && !m_err && m_data == PL_E[c-3],
            $sformatf("R7 back-to-back step %0d", c - 3), m_data, PL_E[c-3]);
      if (c < 4) begin
        chk(m_in_ready, "R2 accepts every cycle", {31'd0, m_in_ready}, 32'd1);
        m_in_valid = 1'b1; m_op = PL_OP[c]; m_a = PL_A[c]; m_b = PL_B[c];
      end else begin
        m_in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(!m_out_valid, "R2 pipeline drained", {31'd0, m_out_valid}, 32'd0);

    // stall with a second operation in flight: R1
    @(negedge clk);
    m_out_ready = 1'b0;
    m_in_valid = 1'b1; m_op = 4'd0; m_a = 32'd1; m_b = 32'd2;
    @(negedge clk);
    m_a = 32'd10; m_b = 32'd20;
    @(negedge clk);
    m_in_valid = 1'b0;
    @(negedge clk);
    chk(m_out_valid && m_data == 32'd3, "R1 first result under stall", m_data, 32'd3);
    chk(!m_in_ready, "R1 in_ready low in stall", {31'd0, m_in_ready}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    chk(m_out_valid && m_data == 32'd3, "R1 result held", m_data, 32'd3);
    m_out_ready = 1'b1;
    @(negedge clk);
    chk(m_out_valid && m_data == 32'd30, "R1 second result after release", m_data, 32'd30);
    @(negedge clk);
    chk(!m_out_valid, "R1 no duplicate after release", {31'd0, m_out_valid}, 32'd0);

    // lane without multiplier: R9
    n_issue(4'd8, 32'd3, 32'd4);
    chk(n_out_valid && n_err && n_data == 32'd0, "R9 mul illegal", n_data, 32'd0);
    n_issue(4'd10, 32'd5, 32'd6);
    chk(n_out_valid && n_err && n_data == 32'd0, "R9 mac illegal", n_data, 32'd0);
    n_issue(4'd0, 32'd1, 32'd1);
    chk(n_out_valid && !n_err && n_data == 32'd2, "R9 add still works", n_data, 32'd2);
    n_issue(4'd11, 32'd9, 32'd0);
    chk(n_out_valid && !n_err && n_data == 32'd9, "R9 acc untouched by mac", n_data, 32'd9);
    chk(!n_sticky, "R8 no clamp no sticky", {31'd0, n_sticky}, 32'd0);

    // reset clears sticky and accumulator: R11 R8
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(!m_sticky && !m_out_valid, "R11 reset clears sticky",
        {30'd0, m_sticky, m_out_valid}, 32'd0);
    m_issue(4'd11, 32'd7, 32'd0);
    chk(m_out_valid && m_data == 32'd7, "R11 accumulator zero after reset", m_data, 32'd7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule